// File: doc/BRIEF.md
# EDO DRAM Refresh and Self-Refresh Controller

This block generates all refresh activity for an EDO DRAM. A free-running interval timer produces refresh ticks; each tick adds one to a pending counter, and the controller serves pending refreshes as CAS-before-RAS (CBR) cycles. In distributed mode each pending refresh is served on its own bus tenure. In burst mode the controller waits until a whole array's worth of ticks has built up and then runs every row back to back in a single tenure.

The controller shares the RAS, CAS and WE lines with an access sequencer. It raises `bus_req`, waits for `bus_grant`, and drives the strobes only while it holds the grant. It drops the request only after the closing precharge has elapsed. Ticks that arrive while the sequencer keeps the bus accumulate in the pending counter. If they exceed a set limit, a sticky error flag is raised.

A host sleep request puts the device into self-refresh. CAS falls, then RAS falls, and both are held low for at least a minimum time and for as long as the request stays up. After exit, RAS stays high for the self-refresh precharge time. The catch-up refresh then depends on the mode: one CBR cycle in distributed mode, or a full array burst both before entry and after exit in burst mode. All times are parameters counted in clock cycles.

Top module: `edo_refresh_ctl`

## Requirements
- R1: In distributed mode (`burst_mode`=0) with the grant given promptly, exactly one CBR cycle is issued for every TICK_CYC clock cycles. `bus_req` falls after each cycle, so there is one request per refresh.
- R2: In every CBR cycle, CAS is low for at least CSR_CYC cycles before RAS falls. CAS stays low for as long as RAS is low. `we_n` is high at all times.
- R3: After RAS rises at the end of a CBR cycle, RAS and CAS stay high for at least RP_CYC cycles before CAS falls again.
- R4: Once raised, `bus_req` stays high until it is granted and for the whole sequence. RAS or CAS is driven low only while `bus_grant` is high.
- R5: Ticks that arrive while the grant is withheld are counted. Up to PEND_MAX of them are all served once the grant returns.
- R6: A tick that arrives while PEND_MAX refreshes are already pending sets `pend_err`. The flag stays set until reset, and the lost tick is never served.
- R7: In burst mode (`burst_mode`=1), no refresh runs until ROWS ticks are pending. ROWS CBR cycles are then issued under a single `bus_req` tenure.
- R8: On `sleep_req`, CAS falls and then RAS falls. `self_ref` is high while RAS is held low. The low time is at least SR_MIN_CYC cycles and lasts for as long as `sleep_req` stays high.
- R9: After self-refresh exit, RAS and CAS stay high for at least SRX_CYC cycles before the next CAS fall.
- R10: Around self-refresh, distributed mode issues no CBR cycle before entry and exactly one after exit. Burst mode issues ROWS CBR cycles immediately before entry and ROWS immediately after exit. `bus_req` is released only after the final cycle.
- R11: During and right after reset, `bus_req`, `self_ref` and `pend_err` are 0, and `ras_n`, `cas_n` and `we_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0: distributed refresh, 1: burst refresh |
| sleep_req | input | 1 | Host request to enter and remain in self-refresh |
| bus_grant | input | 1 | Memory bus granted by the access sequencer |
| bus_req | output | 1 | Memory bus requested by the refresh controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive high |
| self_ref | output | 1 | Device is held in self-refresh |
| pend_err | output | 1 | Sticky pending-counter overflow |

## Verification
The hardest situation to reach is the pending counter sitting exactly at its limit when another tick lands. The bench gets there by withholding the grant from reset for a swept number of tick periods, from one up to one past the limit. It then releases the grant and compares the total count of CBR cycles against the tick arithmetic: every tick is served up to the limit, and exactly one is lost beyond it. The self-refresh paths are reached by raising the sleep request only when the bus is idle. This makes the number of CBR cycles before entry and after exit exact in both modes.

// File: rtl/edo_refresh_ctl.sv
module edo_refresh_ctl #(
  parameter int TICK_CYC   = 6250,
  parameter int ROWS       = 2048,
  parameter int PEND_MAX   = 2100,
  parameter int CSR_CYC    = 1,
  parameter int RAS_CYC    = 5,
  parameter int RP_CYC     = 4,
  parameter int SR_MIN_CYC = 10000,
  parameter int SRX_CYC    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic sleep_req,
  input  logic bus_grant,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic self_ref,
  output logic pend_err
);
  localparam int TW = $clog2(TICK_CYC + 1);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(SR_MIN_CYC + SRX_CYC + RAS_CYC + RP_CYC + CSR_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_CAS, S_RAS, S_PRE, S_SCAS, S_SRAS, S_SPRE
  } st_t;

  st_t           st;
  logic [CW-1:0] ph;
  logic [RW-1:0] left;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pend;
  logic          to_sr, sl;
  int            lim;

  wire in_sr  = st inside {S_SCAS, S_SRAS, S_SPRE};
  wire tick   = !in_sr && (tcnt == TW'(TICK_CYC - 1));
  wire at_lim = (ph == CW'(lim - 1));
  wire dec    = (st == S_PRE) && at_lim && !sl && (pend != '0);
  wire due    = burst_mode ? (pend >= PW'(ROWS)) : (pend != '0);

  assign cas_n    = !(st inside {S_CAS, S_RAS, S_SCAS, S_SRAS});
  assign ras_n    = !(st inside {S_RAS, S_SRAS});
  assign we_n     = 1'b1;
  assign self_ref = (st == S_SRAS);

  always_comb
    case (st)
      S_CAS, S_SCAS: lim = CSR_CYC;
      S_RAS:         lim = RAS_CYC;
      S_PRE:         lim = RP_CYC;
      S_SRAS:        lim = SR_MIN_CYC;
      S_SPRE:        lim = SRX_CYC;
      default:       lim = 1;
    endcase

  always_ff @(posedge clk)
    if (!rst_n || in_sr || tick) tcnt <= '0;
    else                         tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend     <= '0;
      pend_err <= 1'b0;
    end else if (st == S_SRAS) begin
      pend <= '0;
    end else if (tick && !dec) begin
      if (pend == PW'(PEND_MAX)) pend_err <= 1'b1;
      else                       pend <= pend + 1'b1;
    end else if (dec && !tick) begin
      pend <= pend - 1'b1;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      left    <= '0;
      to_sr   <= 1'b0;
      sl      <= 1'b0;
      bus_req <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          ph <= '0;
          if (sleep_req || due) begin
            bus_req <= 1'b1;
            sl      <= sleep_req;
            st      <= S_WAIT;
          end
        end
        S_WAIT:
          if (bus_grant) begin
            ph <= '0;
            if (sl && !burst_mode) st <= S_SCAS;
            else begin
              left  <= burst_mode ? RW'(ROWS) : RW'(1);
              to_sr <= sl;
              st    <= S_CAS;
            end
          end
        S_SRAS: begin
          if (!at_lim) ph <= ph + 1'b1;
          else if (!sleep_req) begin
            ph <= '0;
            st <= S_SPRE;
          end
        end
        default: begin
          ph <= at_lim ? '0 : ph + 1'b1;
          if (at_lim)
            case (st)
              S_CAS:  st <= S_RAS;
              S_RAS:  st <= S_PRE;
              S_SCAS: st <= S_SRAS;
              S_SPRE: begin
                left  <= burst_mode ? RW'(ROWS) : RW'(1);
                to_sr <= 1'b0;
                st    <= S_CAS;
              end
              S_PRE: begin
                left <= left - 1'b1;
                if (left > RW'(1)) st <= S_CAS;
                else if (to_sr)    st <= S_SCAS;
                else begin
                  bus_req <= 1'b0;
                  st      <= S_IDLE;
                end
              end
              default: st <= S_IDLE;
            endcase
        end
      endcase
    end

  AST_CAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> !$past(cas_n)); // R2
  AST_DRIVE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) (!ras_n || !cas_n) |-> bus_grant); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bus_req && !bus_grant) |=> bus_req); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |=> (ras_n && cas_n)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) pend_err |=> pend_err); // R6
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (self_ref && sleep_req) |=> self_ref); // R8
endmodule

// File: tb/edo_refresh_ctl_test.sv
module edo_refresh_ctl_test;
  localparam int TICK = 40, ROWS = 4, PMAX = 6, CSR = 1, RASC = 2, RP = 2, SRMIN = 30, SRX = 3;

  logic clk = 0, rst_n = 0, burst_mode = 0, sleep_req = 0, bus_grant = 0, block = 0;
  logic bus_req, ras_n, cas_n, we_n, self_ref, pend_err;
  int tests = 0, fails = 0, cyc = 0;
  int cbr, sr_cnt, sr_dur, req_rises, v_r2, v_r3, v_r4, v_r9;
  int pre_cas, ras_lo, hi_run;
  logic p_ras, p_cas, p_req, post_sr;

  edo_refresh_ctl #(.TICK_CYC(TICK), .ROWS(ROWS), .PEND_MAX(PMAX), .CSR_CYC(CSR), .RAS_CYC(RASC),
    .RP_CYC(RP), .SR_MIN_CYC(SRMIN), .SRX_CYC(SRX)) uut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .sleep_req(sleep_req), .bus_grant(bus_grant),
    .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .self_ref(self_ref), .pend_err(pend_err));

  initial forever #5 clk = ~clk;

  always @(posedge clk) bus_grant <= block ? 1'b0 : bus_req;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      cbr = 0; sr_cnt = 0; sr_dur = 0; req_rises = 0; v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r9 = 0;
      pre_cas = 0; ras_lo = 0; hi_run = 100; p_ras = 1; p_cas = 1; p_req = 0; post_sr = 0;
    end else begin
      if (p_ras && !ras_n && pre_cas < CSR) v_r2++;
      if (!ras_n && cas_n) v_r2++;
      if (!we_n) v_r2++;
      if ((!ras_n || !cas_n) && !bus_grant) v_r4++;
      if (!p_ras && ras_n) begin
        if (ras_lo < SRMIN) cbr++;
        else begin sr_cnt++; sr_dur = ras_lo; post_sr = 1; end
      end
      if (p_cas && !cas_n) begin
        if (post_sr && hi_run < SRX) v_r9++;
        if (!post_sr && hi_run < RP) v_r3++;
        post_sr = 0;
      end
      if (!p_req && bus_req) req_rises++;
      if (!cas_n && ras_n) pre_cas++; else if (cas_n) pre_cas = 0;
      if (!ras_n) begin ras_lo++; hi_run = 0; end
      else begin
        if (p_ras == 0) ras_lo = 0;
        if (cas_n) hi_run++;
      end
      if (!p_ras && ras_n) ras_lo = 0;
      p_ras = ras_n; p_cas = cas_n; p_req = bus_req;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lo);
    tests++;
    if (act < lo) begin
      fails++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(logic mode, logic blk);
    rst_n = 0; burst_mode = mode; block = blk; sleep_req = 0;
    step(3);
    rst_n = 1;
  endtask

  task automatic sleep_run(int hold, int exp_pre, int exp_post, int min_dur, string tag);
    int c = 0, base, pre = -1, post = -1;
    bit seen = 0, out = 0, done = 0;
    while (bus_req) step(1);
    base = cbr;
    sleep_req = 1;
    while (!done) begin
      step(1);
      c++;
      if (c == hold) sleep_req = 0;
      if (!seen && self_ref) begin seen = 1; pre = cbr - base; end
      if (seen && !out && !self_ref) begin out = 1; base = cbr; end
      if (out && !bus_req) begin post = cbr - base; done = 1; end
    end
    chk({tag, " R10 CBR before entry"}, pre, exp_pre);
    chk({tag, " R10 CBR after exit"}, post, exp_post);
    chk_ge({tag, " R8 self-refresh RAS low time"}, sr_dur, min_dur);
    chk({tag, " R9 exit precharge violations"}, v_r9, 0);
  endtask

  initial begin
    step(1);
    chk("R11 bus_req in reset", bus_req, 0);
    chk("R11 ras_n in reset", ras_n, 1);
    chk("R11 cas_n in reset", cas_n, 1);
    chk("R11 we_n in reset", we_n, 1);
    chk("R11 self_ref in reset", self_ref, 0);
    chk("R11 pend_err in reset", pend_err, 0);

    do_reset(0, 0);
    step(10 * TICK + 12);
    chk("R1 distributed CBR count", cbr, 10);
    chk("R1 one request per refresh", req_rises, 10);
    chk("R2 waveform violations", v_r2, 0);
    chk("R3 precharge violations", v_r3, 0);
    chk("R4 strobe without grant", v_r4, 0);

    for (int k = 1; k <= PMAX + 1; k++) begin
      do_reset(0, 1);
      step(k * TICK + 5);
      chk($sformatf("R4 request held while blocked k=%0d", k), bus_req, 1);
      chk($sformatf("R5 nothing served while blocked k=%0d", k), cbr, 0);
      block = 0;
      step(3 * TICK + 7);
      chk($sformatf("R5 catch-up CBR count k=%0d", k), cbr, (k <= PMAX) ? k + 3 : k + 2);
      chk($sformatf("R6 overflow flag k=%0d", k), pend_err, (k > PMAX) ? 1 : 0);
      chk($sformatf("R4 no strobe without grant k=%0d", k), v_r4, 0);
    end

    do_reset(1, 0);
    step(3 * TICK + 30);
    chk("R7 no burst before ROWS pending", cbr, 0);
    step(TICK + 15);
    chk("R7 first burst count", cbr, ROWS);
    chk("R7 single tenure for first burst", req_rises, 1);
    step(4 * TICK);
    chk("R7 second burst count", cbr, 2 * ROWS);
    chk("R7 single tenure per burst", req_rises, 2);
    chk("R2 burst waveform violations", v_r2, 0);
    chk("R3 burst precharge violations", v_r3, 0);

    do_reset(0, 0);
    step(TICK + 15);
    sleep_run(5, 0, 1, SRMIN, "dist short");
    sleep_run(60, 0, 1, SRMIN + 20, "dist long");

    do_reset(1, 0);
    step(10);
    sleep_run(5, ROWS, ROWS, SRMIN, "burst short");
    chk("R2 self-refresh waveform violations", v_r2, 0);
    chk("R4 self-refresh strobe without grant", v_r4, 0);
    chk("R8 self_ref cleared after exit", self_ref, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule